// File: doc/BRIEF.md
# Bit-Aligned Frame Delineator

The block takes a stream of wide data words over a valid/ready handshake and recovers frames that may begin at any bit position in that stream. Each accepted word is appended behind the bits still held in an internal shift buffer. The most significant bit of each word is the earliest bit in time. A small state machine walks the buffer one bit per cycle until it finds a two-bit sync marker immediately followed by a four-bit start nibble. It then reads a length field and streams the payload out as bytes, one byte per step, marking the first and last byte of each frame.

Marker search is switched off for as long as a payload is being forwarded, so payload bits that happen to look like a header never open a false frame. One word can hold several short frames, and one frame can stretch over many words. Downstream backpressure stalls the buffer without losing any bit.

Top module: `frame_delineator`

## Requirements
- R1: After synchronous reset the output is idle (`out_valid` low) and the block asks for input (`in_ready` high).
- R2: A frame header is the six-bit sequence 0,1,1,1,1,1 in time order: sync bits 0 then 1, then a start nibble of four ones. It is found at any bit offset, and the first byte forwarded after it carries `out_sof`.
- R3: When sync bits 01 are followed by a nibble other than 1111, the search moves on by one bit from the sync position, so a true header starting one or two bits later is still found.
- R4: The 8 bits after the header are an unsigned payload byte count. Exactly that many bytes follow, in stream order, the last with `out_eof`, and no other byte is produced.
- R5: A length value below 4, including 0, is treated as 4, so four payload bytes are forwarded.
- R6: Bits inside a payload are never tested for a header, even when payload bytes contain 0,1,1,1,1,1; the search resumes at the first bit after the last payload byte.
- R7: Several frames inside one input word, back-to-back frames with no gap, and frames spanning many input words are all delineated correctly.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values.
- R9: `in_ready` is high only when the buffer holds fewer bits than the current step needs. An accepted word is placed directly behind the bits already held.
- R10: Within `in_data`, bit WORD_W-1 is the earliest bit, and payload bytes are assembled most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block will accept a word at this edge |
| in_data | input | WORD_W | Input word, MSB earliest |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |

## Verification
A word is taken at the edge where `in_valid` and `in_ready` are both high. From then on, the search spends one cycle per rejected bit offset, one cycle on the header and one on the length, and forwards one byte per cycle while the output register is free. Each byte is visible on the outputs from the edge after its bits are shifted out of the buffer. Because these delays depend on how much junk precedes each header and on backpressure, the scoreboard checks order and content rather than fixed cycle positions. It samples all handshakes shortly after the falling edge, when the values that the next rising edge will use are settled. The hold rule under stall is checked cycle by cycle against the previous sample.

// File: rtl/fd_pkg.sv
package fd_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_LEN  = 2'd1,
      ST_PAY  = 2'd2
   } fd_state_e;

   localparam int          HDR_W    = 6;
   localparam logic [5:0]  HDR_PATT = 6'b011111;
   localparam int          BYTE_W   = 8;
endpackage

// File: rtl/fd_shift_buf.sv
module fd_shift_buf #(
   parameter int WORD_W = 64,
   parameter int PAD_W  = 8,
   parameter int BUF_W  = WORD_W + PAD_W,
   parameter int BCNT_W = $clog2(BUF_W + 1),
   parameter int AMT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              load_en,
   input  logic [WORD_W-1:0] load_word,
   output logic [7:0]        head,
   output logic [BCNT_W-1:0] bit_cnt
);
   logic [BUF_W-1:0]  buf_q;
   logic [BCNT_W-1:0] cnt_q;
   logic [BUF_W-1:0]  word_ext;

   if (PAD_W < 8) begin : g_bad_pad
      $error("fd_shift_buf: PAD_W must be at least 8");
   end
   if (WORD_W < 8) begin : g_bad_word
      $error("fd_shift_buf: WORD_W must be at least 8");
   end

   assign word_ext = {load_word, {PAD_W{1'b0}}};
   assign head     = buf_q[BUF_W-1 -: 8];
   assign bit_cnt  = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         buf_q <= buf_q << shift_amt;
         cnt_q <= cnt_q - BCNT_W'(shift_amt);
      end else if (load_en) begin
         buf_q <= buf_q | (word_ext >> cnt_q);
         cnt_q <= cnt_q + BCNT_W'(WORD_W);
      end
   end

   AST_SHIFT_WITHIN: assert property (@(posedge clk) disable iff (rst)
      shift_en |-> (BCNT_W'(shift_amt) <= bit_cnt)) else $error("shift beyond held bits"); // R9
   AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (rst)
      load_en |-> (bit_cnt < BCNT_W'(PAD_W))) else $error("load without room"); // R9
   AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
      (load_en && !shift_en && bit_cnt == '0) |=> (head == $past(load_word[WORD_W-1 -: 8])))
      else $error("word MSB not at buffer head"); // R10
endmodule

// File: rtl/fd_frame_fsm.sv
module fd_frame_fsm
   import fd_pkg::*;
#(
   parameter int PCNT_W  = 13,
   parameter int LEN_W   = 8,
   parameter int MIN_LEN = 4,
   parameter int BCNT_W  = 7,
   parameter int AMT_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BCNT_W-1:0] bit_cnt,
   input  logic [7:0]        head,
   input  logic              in_valid,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              load_en,
   output logic              shift_en,
   output logic [AMT_W-1:0]  shift_amt,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_sof,
   output logic              out_eof
);
   localparam logic [BCNT_W-1:0] NEED_HUNT = BCNT_W'(HDR_W);
   localparam logic [BCNT_W-1:0] NEED_LEN  = BCNT_W'(LEN_W);
   localparam logic [BCNT_W-1:0] NEED_PAY  = BCNT_W'(BYTE_W);
   localparam logic [PCNT_W-1:0] MIN_CNT   = PCNT_W'(MIN_LEN);

   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("fd_frame_fsm: LEN_W must be 1..8");
   end
   if (PCNT_W < LEN_W || MIN_LEN < 1 || MIN_LEN >= (1 << PCNT_W)) begin : g_bad_cnt
      $error("fd_frame_fsm: payload counter too narrow");
   end

   fd_state_e         state_q;
   logic [PCNT_W-1:0] rem_q;
   logic              first_q;
   logic [BCNT_W-1:0] need;
   logic              have;
   logic              hdr_hit;
   logic              out_free;
   logic              step;
   logic [PCNT_W-1:0] len_ext;
   logic [PCNT_W-1:0] len_eff;

   if (PCNT_W > LEN_W) begin : g_len_pad
      assign len_ext = {{(PCNT_W-LEN_W){1'b0}}, head[7 -: LEN_W]};
   end else begin : g_len_direct
      assign len_ext = head[7 -: LEN_W];
   end
   assign len_eff  = (len_ext < MIN_CNT) ? MIN_CNT : len_ext;

   assign hdr_hit  = (head[7 -: HDR_W] == HDR_PATT);
   assign out_free = !out_valid || out_ready;

   always_comb begin
      unique case (state_q)
         ST_HUNT: need = NEED_HUNT;
         ST_LEN:  need = NEED_LEN;
         default: need = NEED_PAY;
      endcase
      have = (bit_cnt >= need);
      unique case (state_q)
         ST_HUNT: begin
            step      = have;
            shift_amt = hdr_hit ? AMT_W'(HDR_W) : AMT_W'(1);
         end
         ST_LEN: begin
            step      = have;
            shift_amt = AMT_W'(LEN_W);
         end
         default: begin
            step      = have && out_free;
            shift_amt = AMT_W'(BYTE_W);
         end
      endcase
   end

   assign shift_en = step;
   assign in_ready = !have;
   assign load_en  = in_valid && !have;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_HUNT;
         rem_q     <= '0;
         first_q   <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
      end else begin
         if (out_ready) out_valid <= 1'b0;
         unique case (state_q)
            ST_HUNT: if (step && hdr_hit) state_q <= ST_LEN;
            ST_LEN: if (step) begin
               rem_q   <= len_eff;
               first_q <= 1'b1;
               state_q <= ST_PAY;
            end
            default: if (step) begin
               out_valid <= 1'b1;
               out_data  <= head;
               out_sof   <= first_q;
               out_eof   <= (rem_q == PCNT_W'(1));
               first_q   <= 1'b0;
               rem_q     <= rem_q - PCNT_W'(1);
               if (rem_q == PCNT_W'(1)) state_q <= ST_HUNT;
            end
         endcase
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)))
      else $error("output changed under stall"); // R8
   AST_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PAY && $past(state_q) == ST_LEN) |-> (rem_q >= MIN_CNT))
      else $error("length below minimum"); // R5
   AST_REM_LIVE: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PAY) |-> (rem_q != '0)) else $error("payload counter empty in payload"); // R4
   AST_IN_READY_SHORT: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> (bit_cnt < NEED_PAY)) else $error("ready with enough bits"); // R9
   AST_EOF_ENDS: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_eof && !$stable(out_data)) |-> (state_q == ST_HUNT))
      else $error("search not resumed after last byte"); // R6
endmodule

// File: rtl/frame_delineator.sv
module frame_delineator #(
   parameter int WORD_W  = 64,
   parameter int LEN_W   = 8,
   parameter int PCNT_W  = 13,
   parameter int MIN_LEN = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_sof,
   output logic              out_eof
);
   localparam int PAD_W  = 8;
   localparam int BUF_W  = WORD_W + PAD_W;
   localparam int BCNT_W = $clog2(BUF_W + 1);
   localparam int AMT_W  = 4;

   logic              shift_en;
   logic [AMT_W-1:0]  shift_amt;
   logic              load_en;
   logic [7:0]        head;
   logic [BCNT_W-1:0] bit_cnt;

   fd_shift_buf #(
      .WORD_W (WORD_W),
      .PAD_W  (PAD_W),
      .BUF_W  (BUF_W),
      .BCNT_W (BCNT_W),
      .AMT_W  (AMT_W)
   ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (shift_en),
      .shift_amt (shift_amt),
      .load_en   (load_en),
      .load_word (in_data),
      .head      (head),
      .bit_cnt   (bit_cnt)
   );

   fd_frame_fsm #(
      .PCNT_W  (PCNT_W),
      .LEN_W   (LEN_W),
      .MIN_LEN (MIN_LEN),
      .BCNT_W  (BCNT_W),
      .AMT_W   (AMT_W)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .bit_cnt   (bit_cnt),
      .head      (head),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .load_en   (load_en),
      .shift_en  (shift_en),
      .shift_amt (shift_amt),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sof   (out_sof),
      .out_eof   (out_eof)
   );
endmodule

// File: tb/frame_delineator_tb.sv
module frame_delineator_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 64;
   localparam int WDOG       = 150000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [WORD_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [7:0]        out_data;
   logic              out_sof;
   logic              out_eof;

   int n_checks = 0;
   int n_fail   = 0;
   bit drv_done = 1'b0;
   bit mon_en   = 1'b0;
   int stall_mode = 0;

   logic [9:0] exp_q[$];
   bit         bq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_delineator #(.WORD_W(WORD_W)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bq.push_back(v[i]);
   endtask

   // junk with a forced zero every fourth bit can never hold five ones in a row
   task automatic push_junk(input int n);
      for (int i = 0; i < n; i++) bq.push_back((i % 4 == 3) ? 1'b0 : 1'($urandom % 2));
   endtask

   // mode 0 random bytes, mode 1 mixes header-like 0x7C bytes (R6)
   task automatic add_frame(input int lenf, input int mode);
      int n;
      logic [7:0] b;
      push_bits(32'b011111, 6);           // R2 header
      push_bits(32'(lenf), 8);            // R4 length byte
      n = (lenf < 4) ? 4 : lenf;          // R5 clamp
      for (int k = 0; k < n; k++) begin
         b = (mode == 1 && (k % 3) != 2) ? 8'h7C : 8'($urandom);
         push_bits(32'(b), 8);
         exp_q.push_back({(k == 0), (k == n - 1), b});
      end
   endtask

   task automatic drive_stream();
      int nw;
      logic [WORD_W-1:0] w;
      nw = bq.size() / WORD_W;
      for (int wi = 0; wi < nw; wi++) begin
         for (int b = 0; b < WORD_W; b++) w[WORD_W-1-b] = bq[wi*WORD_W + b]; // R10
         if ($urandom % 5 == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         forever begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = w;
            #1;
            if (in_ready) break;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      drv_done = 1'b1;
   endtask

   // downstream ready pattern
   initial begin
      forever begin
         @(negedge clk);
         if (stall_mode == 0) out_ready = 1'b1;
         else if (stall_mode == 1) out_ready = ($urandom % 3 != 0);
         else out_ready = ($urandom % 4 == 0);
      end
   end

   // monitor and scoreboard
   initial begin
      logic       pv, pr;
      logic [9:0] pitem;
      logic [9:0] got;
      logic [9:0] e;
      pv = 1'b0; pr = 1'b0; pitem = '0;
      forever begin
         @(negedge clk);
         #2;
         if (mon_en) begin
            got = {out_sof, out_eof, out_data};
            if (pv && !pr)
               chk(out_valid && got == pitem, "R8", "hold under stall", int'({out_valid, got}), int'({1'b1, pitem}));
            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4", "unexpected byte", int'(got), 0);
               end else begin
                  e = exp_q.pop_front();
                  // R2 sof, R4 eof and order, R6 marker-like payload, R7 spanning, R3 late header
                  chk(got == e, "R2 R4 R6 R7", "payload byte {sof,eof,data}", int'(got), int'(e));
               end
            end
            pv = out_valid; pr = out_ready; pitem = got;
         end
      end
   end

   initial begin
      int cyc;
      // build the stream
      push_junk(13);
      add_frame(5, 0);                           // R2 non-aligned start
      push_bits(32'b01, 2);                      // R3 sync then failed nibble
      add_frame(6, 0);
      push_bits(32'b011110, 6);                  // R3 sync with 1110 nibble
      add_frame(4, 1);
      add_frame(0, 0);                           // R5 zero length
      add_frame(1, 1);                           // R5
      add_frame(3, 0);                           // R5, back-to-back in one word R7
      push_junk(3);
      add_frame(200, 1);                         // R6 R7 long frame with markers
      add_frame(9, 1);                           // R6 header right after payload
      push_junk(37);
      add_frame(255, 0);                         // R4 largest byte value
      push_junk(5);
      add_frame(7, 1);
      push_junk(WORD_W);
      while (bq.size() % WORD_W != 0) bq.push_back(1'b0);

      repeat (3) @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      @(negedge clk);
      rst = 1'b0;
      #2;
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      repeat (2) @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R9", "no output without input", int'(out_valid), 0);
      mon_en = 1'b1;

      fork
         drive_stream();
      join_none

      cyc = 0;
      while (!(drv_done && exp_q.size() == 0)) begin
         @(negedge clk);
         cyc++;
         if (cyc == 300) stall_mode = 1;
         if (cyc == 900) stall_mode = 2;
         if (cyc == 1500) stall_mode = 1;
         if (cyc > WDOG) begin
            chk(1'b0, "R4", "watchdog expired", exp_q.size(), 0);
            break;
         end
      end
      stall_mode = 0;
      repeat (40) @(negedge clk);
      #3;
      chk(exp_q.size() == 0, "R4", "all expected bytes seen", exp_q.size(), 0);
      chk(out_valid == 1'b0, "R6", "idle after last frame", int'(out_valid), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule